// File: doc/BRIEF.md
# Instruction Fetch Cache with Profiling Counters

This block is a read-only instruction cache that sits between a processor's fetch port and the read port of an on-chip flash array. It holds 2048 bytes as a direct-mapped store of 16-byte lines. A fetch that hits is answered in the same cycle it is presented. A fetch that misses pulls the whole line from flash one word at a time, where each flash word costs a parameterised number of wait cycles. The requested word is then answered from the freshly filled line.

Software controls the cache through a small configuration register. One bit turns the cache on. Another bit turns on profiling, and while profiling is on, two 32-bit counters tally hits and misses. Software can load either counter, and writing zero clears it. While the flash is in any program or erase mode, the cache is emptied and kept empty, so a fetch can never return stale code. Turning the cache off also discards its contents. In both cases, fetches go straight to flash one word at a time and are not counted.

Top module: `fetch_icache`

## Requirements
- R1: A fetch whose line is present and valid asserts `fetchReady` in the same cycle that `fetchReq` is first presented, with the cached word on `fetchData`.
- R2: On a miss, the block reads the four words of the line from flash in ascending order, starting at word 0 of the line. Each word holds `flashAddr` for FLASH_WAIT cycles. `fetchReady` is asserted 4*FLASH_WAIT+1 cycles after the request is first presented, carrying the requested word.
- R3: The cache is direct-mapped with 128 lines of 16 bytes. Byte address bits [3:2] select the word, bits [10:4] select the line, and the bits above form the tag. A fetch with the same line index but a different tag misses and replaces the line.
- R4: The configuration register reads back its written value in bit 0 (cache enable) and bit 8 (profiling enable), with all other bits zero. It resets to 0.
- R5: Clearing the enable bit invalidates every line. While the cache is disabled, a fetch reads only the requested word from flash, answers FLASH_WAIT+1 cycles after it is presented, and is not counted.
- R6: While any bit of `flashMode` is set (bit 0 write, bit 1 erase, bit 2 partial erase), every line is invalid and stays invalid. Fetches behave as in R5. The first cached fetch after the mode clears is a miss.
- R7: With profiling enabled, the hit counter increments by one per hit and the miss counter by one per miss. With profiling disabled, both counters hold their values.
- R8: A counter write loads `cntWrData` into the selected counter, so writing zero clears it. A counter write takes precedence over an increment in the same cycle. Both counters reset to 0.
- R9: `fetchReady` is asserted only while `fetchReq` is high, and never in a cycle where a flash read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Write strobe for the configuration register |
| cfgWrData | input | 32 | Configuration write data (bit 0 enable, bit 8 profiling) |
| cfgRdData | output | 32 | Configuration register readback |
| hitWrEn | input | 1 | Load strobe for the hit counter |
| missWrEn | input | 1 | Load strobe for the miss counter |
| cntWrData | input | 32 | Value loaded into the selected counter |
| hitCount | output | 32 | Hit counter |
| missCount | output | 32 | Miss counter |
| flashMode | input | 3 | Flash program/erase mode flags: write, erase, partial erase |
| fetchReq | input | 1 | Fetch request, held with its address until `fetchReady` |
| fetchAddr | input | ADDR_W | Fetch byte address |
| fetchReady | output | 1 | Fetch answered this cycle |
| fetchData | output | 32 | Fetched instruction word |
| flashRdEn | output | 1 | Flash read in progress |
| flashAddr | output | ADDR_W-2 | Flash word address |
| flashRdata | input | 32 | Flash read data, sampled at the last wait cycle of each word |

## Verification
Each result has a fixed cycle in which it is due. A hit answers in cycle 0 of the request. A miss answers in cycle 4*FLASH_WAIT+1, which is 13 with the bench's FLASH_WAIT of 3. A bypassed fetch answers in cycle FLASH_WAIT+1, which is 4. Counter and configuration updates are visible from the first clock edge after their strobe. The bench drives inputs on the falling edge and samples one nanosecond later. It counts falling edges from the request to `fetchReady` and compares that count exactly against the expected latency. The flash model's data depends on a salt that the bench changes between scenarios, so the returned word shows whether it came from the cache or from a new flash read.

// File: rtl/fetch_icache_pkg.sv
package fetch_icache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_BYP,
    ST_RESP
  } ctrlState_t;

  typedef enum logic [1:0] {
    SEL_LOOKUP,
    SEL_LINE,
    SEL_BYP
  } dataSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     latchReq;
    logic     flashRd;
    logic     fillMode;
    logic     lineWr;
    logic     setValid;
    logic     bypCap;
    logic     incHit;
    logic     incMiss;
    dataSel_t dataSel;
  } dpStrobe_t;

  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_PROF_BIT = 8;

endpackage

// File: rtl/fetch_icache_ctrl.sv
module fetch_icache_ctrl
  import fetch_icache_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  parameter int FLASH_WAIT = 3,
  localparam int WORD_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
  localparam int WAIT_W = (FLASH_WAIT > 1) ? $clog2(FLASH_WAIT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic              lookupHit,
  input  logic              effEn,
  input  logic              profEn,
  output logic              fetchReady,
  output dpStrobe_t         st,
  output logic [WORD_W-1:0] fillWord
);

  ctrlState_t        stateQ, stateD;
  logic [WAIT_W-1:0] waitQ;
  logic [WORD_W-1:0] wordQ;
  dataSel_t          respSelQ;
  logic              waitLast;
  logic              wordLast;

  assign waitLast = (waitQ == WAIT_W'(FLASH_WAIT - 1));
  assign wordLast = (wordQ == WORD_W'(LINE_WORDS - 1));
  assign fillWord = wordQ;

  always_comb begin
    stateD     = stateQ;
    fetchReady = 1'b0;
    st         = '0;
    st.dataSel = SEL_LOOKUP;
    unique case (stateQ)
      ST_IDLE: begin
        if (fetchReq) begin
          if (lookupHit) begin
            fetchReady = 1'b1;
            st.incHit  = profEn;
          end else begin
            st.latchReq = 1'b1;
            if (effEn) begin
              st.incMiss = profEn;
              stateD     = ST_FILL;
            end else begin
              stateD = ST_BYP;
            end
          end
        end
      end
      ST_FILL: begin
        st.flashRd  = 1'b1;
        st.fillMode = 1'b1;
        if (waitLast) begin
          st.lineWr = 1'b1;
          if (wordLast) begin
            st.setValid = 1'b1;
            stateD      = ST_RESP;
          end
        end
      end
      ST_BYP: begin
        st.flashRd = 1'b1;
        if (waitLast) begin
          st.bypCap = 1'b1;
          stateD    = ST_RESP;
        end
      end
      ST_RESP: begin
        fetchReady = 1'b1;
        st.dataSel = respSelQ;
        stateD     = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      waitQ    <= '0;
      wordQ    <= '0;
      respSelQ <= SEL_LINE;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_FILL || stateQ == ST_BYP) begin
        waitQ <= waitLast ? '0 : waitQ + 1'b1;
      end else begin
        waitQ <= '0;
      end
      if (stateQ == ST_FILL) begin
        if (waitLast) wordQ <= wordQ + 1'b1;
      end else begin
        wordQ <= '0;
      end
      if (st.latchReq) respSelQ <= effEn ? SEL_LINE : SEL_BYP;
    end
  end

endmodule

// File: rtl/fetch_icache_dp.sv
module fetch_icache_dp
  import fetch_icache_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int CACHE_BYTES = 2048,
  parameter int LINE_BYTES  = 16,
  parameter int CNT_W       = 32,
  localparam int LINE_WORDS = LINE_BYTES / 4,
  localparam int LINES      = CACHE_BYTES / LINE_BYTES,
  localparam int WORD_W     = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
  localparam int IDX_W      = $clog2(LINES),
  localparam int WADDR_W    = ADDR_W - 2,
  localparam int TAG_W      = WADDR_W - WORD_W - IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [31:0]        cfgWrData,
  output logic [31:0]        cfgRdData,
  input  logic               hitWrEn,
  input  logic               missWrEn,
  input  logic [CNT_W-1:0]   cntWrData,
  output logic [CNT_W-1:0]   hitCount,
  output logic [CNT_W-1:0]   missCount,
  input  logic [2:0]         flashMode,
  input  logic [ADDR_W-1:0]  fetchAddr,
  input  logic [31:0]        flashRdata,
  input  dpStrobe_t          st,
  input  logic [WORD_W-1:0]  fillWord,
  output logic               lookupHit,
  output logic               effEn,
  output logic               profEn,
  output logic [31:0]        fetchData,
  output logic [WADDR_W-1:0] flashAddr
);

  logic enQ, profQ;
  logic [CNT_W-1:0]   hitQ, missQ;
  logic [WADDR_W-1:0] missAddrQ;
  logic [31:0]        bypQ;
  logic [LINES-1:0]   validQ;
  logic [TAG_W-1:0]   tagMem  [LINES];
  logic [31:0]        dataMem [LINES*LINE_WORDS];

  logic [WADDR_W-1:0] reqWaddr;
  logic [TAG_W-1:0]   reqTag, missTag;
  logic [IDX_W-1:0]   reqIdx, missIdx;
  logic [WORD_W-1:0]  reqWord, missWord;
  logic               unusedBits;

  assign unusedBits = &{1'b0, fetchAddr[1:0], cfgWrData[31:CFG_PROF_BIT+1],
                        cfgWrData[CFG_PROF_BIT-1:CFG_EN_BIT+1]};

  assign reqWaddr = fetchAddr[ADDR_W-1:2];
  assign reqWord  = reqWaddr[WORD_W-1:0];
  assign reqIdx   = reqWaddr[WORD_W +: IDX_W];
  assign reqTag   = reqWaddr[WADDR_W-1 -: TAG_W];
  assign missWord = missAddrQ[WORD_W-1:0];
  assign missIdx  = missAddrQ[WORD_W +: IDX_W];
  assign missTag  = missAddrQ[WADDR_W-1 -: TAG_W];

  // program/erase modes hold the cache empty
  assign effEn  = enQ && (flashMode == 3'b000);
  assign profEn = profQ;

  assign lookupHit = effEn && validQ[reqIdx] && (tagMem[reqIdx] == reqTag);

  assign flashAddr = st.fillMode ? {missAddrQ[WADDR_W-1:WORD_W], fillWord}
                                 : missAddrQ;

  always_comb begin
    unique case (st.dataSel)
      SEL_LINE: fetchData = dataMem[{missIdx, missWord}];
      SEL_BYP:  fetchData = bypQ;
      default:  fetchData = dataMem[{reqIdx, reqWord}];
    endcase
  end

  assign cfgRdData = {{(31-CFG_PROF_BIT){1'b0}}, profQ,
                      {(CFG_PROF_BIT-1){1'b0}}, enQ};
  assign hitCount  = hitQ;
  assign missCount = missQ;

  // configuration and counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      profQ <= 1'b0;
      hitQ  <= '0;
      missQ <= '0;
    end else begin
      if (cfgWrEn) begin
        enQ   <= cfgWrData[CFG_EN_BIT];
        profQ <= cfgWrData[CFG_PROF_BIT];
      end
      if (hitWrEn)         hitQ <= cntWrData;
      else if (st.incHit)  hitQ <= hitQ + 1'b1;
      if (missWrEn)        missQ <= cntWrData;
      else if (st.incMiss) missQ <= missQ + 1'b1;
    end
  end

  // request capture and line validity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      missAddrQ <= '0;
      bypQ      <= '0;
      validQ    <= '0;
    end else begin
      if (st.latchReq) missAddrQ <= reqWaddr;
      if (st.bypCap)   bypQ <= flashRdata;
      if (!effEn) begin
        validQ <= '0;
      end else if (st.setValid) begin
        validQ[missIdx] <= 1'b1;
      end else if (st.lineWr) begin
        validQ[missIdx] <= 1'b0;
      end
    end
  end

  // storage arrays, no reset
  always_ff @(posedge clk) begin
    if (st.lineWr) dataMem[{missIdx, fillWord}] <= flashRdata;
    if (st.setValid) tagMem[missIdx] <= missTag;
  end

endmodule

// File: rtl/fetch_icache.sv
module fetch_icache
  import fetch_icache_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int CACHE_BYTES = 2048,
  parameter int LINE_BYTES  = 16,
  parameter int FLASH_WAIT  = 3,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic              hitWrEn,
  input  logic              missWrEn,
  input  logic [CNT_W-1:0]  cntWrData,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount,
  input  logic [2:0]        flashMode,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchReady,
  output logic [31:0]       fetchData,
  output logic              flashRdEn,
  output logic [ADDR_W-3:0] flashAddr,
  input  logic [31:0]       flashRdata
);

  localparam int LINE_WORDS = LINE_BYTES / 4;
  localparam int WORD_W     = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;

  dpStrobe_t         st;
  logic [WORD_W-1:0] fillWord;
  logic              lookupHit, effEn, profEn;

  assign flashRdEn = st.flashRd;

  fetch_icache_ctrl #(
    .LINE_WORDS(LINE_WORDS),
    .FLASH_WAIT(FLASH_WAIT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fetchReq  (fetchReq),
    .lookupHit (lookupHit),
    .effEn     (effEn),
    .profEn    (profEn),
    .fetchReady(fetchReady),
    .st        (st),
    .fillWord  (fillWord)
  );

  fetch_icache_dp #(
    .ADDR_W     (ADDR_W),
    .CACHE_BYTES(CACHE_BYTES),
    .LINE_BYTES (LINE_BYTES),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .hitWrEn   (hitWrEn),
    .missWrEn  (missWrEn),
    .cntWrData (cntWrData),
    .hitCount  (hitCount),
    .missCount (missCount),
    .flashMode (flashMode),
    .fetchAddr (fetchAddr),
    .flashRdata(flashRdata),
    .st        (st),
    .fillWord  (fillWord),
    .lookupHit (lookupHit),
    .effEn     (effEn),
    .profEn    (profEn),
    .fetchData (fetchData),
    .flashAddr (flashAddr)
  );

endmodule

// File: rtl/fetch_icache_chk.sv
module fetch_icache_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [31:0]      cfgRdData,
  input logic             hitWrEn,
  input logic             missWrEn,
  input logic [CNT_W-1:0] cntWrData,
  input logic [CNT_W-1:0] hitCount,
  input logic [CNT_W-1:0] missCount,
  input logic [2:0]       flashMode,
  input logic             fetchReq,
  input logic             fetchReady,
  input logic             flashRdEn
);

  p_ready_needs_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    fetchReady |-> fetchReq);

  p_no_ready_during_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    flashRdEn |-> !fetchReady);

  p_hit_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgRdData[8] && !hitWrEn) |=> $stable(hitCount));

  p_miss_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgRdData[8] && !missWrEn) |=> $stable(missCount));

  p_hit_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    !hitWrEn |=> (hitCount == $past(hitCount)) || (hitCount == $past(hitCount) + 1'b1));

  p_miss_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    !missWrEn |=> (missCount == $past(missCount)) || (missCount == $past(missCount) + 1'b1));

  p_hit_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    hitWrEn |=> hitCount == $past(cntWrData));

  p_miss_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    missWrEn |=> missCount == $past(cntWrData));

  // held-invalid cache: every answer follows a flash read
  p_mode_no_hit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReady && (flashMode != 3'b000) && $past(flashMode != 3'b000)) |-> $past(flashRdEn));

endmodule

bind fetch_icache fetch_icache_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/fetch_icache_tb.sv
`timescale 1ns/1ps
module fetch_icache_tb;

  localparam int WAIT = 3;
  localparam int MISS_LAT = 4 * WAIT + 1;
  localparam int BYP_LAT = WAIT + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        hitWrEn = 1'b0, missWrEn = 1'b0;
  logic [31:0] cntWrData = '0;
  logic [31:0] hitCount, missCount;
  logic [2:0]  flashMode = '0;
  logic        fetchReq = 1'b0;
  logic [19:0] fetchAddr = '0;
  logic        fetchReady;
  logic [31:0] fetchData;
  logic        flashRdEn;
  logic [17:0] flashAddr;
  logic [31:0] flashRdata;
  logic [31:0] salt = '0;

  int nChecks = 0;
  int nFail = 0;
  int expHit = 0;
  int expMiss = 0;
  logic [17:0] firstFa, lastFa;

  always #2 clk = ~clk;

  // flash model: content depends on the address and a salt
  assign flashRdata = {flashAddr[13:0], flashAddr} ^ salt;

  function automatic logic [31:0] fdata(input logic [17:0] wa, input logic [31:0] s);
    return {wa[13:0], wa} ^ s;
  endfunction

  fetch_icache #(.FLASH_WAIT(WAIT)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .hitWrEn(hitWrEn), .missWrEn(missWrEn),
    .cntWrData(cntWrData), .hitCount(hitCount), .missCount(missCount),
    .flashMode(flashMode), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchReady(fetchReady), .fetchData(fetchData), .flashRdEn(flashRdEn),
    .flashAddr(flashAddr), .flashRdata(flashRdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [31:0] d);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk); cfgWrEn = 1'b0;
    #1 check(cfgRdData == d, "R4", "config readback", cfgRdData, d);
  endtask

  task automatic writeCnt(input bit hitSel, input logic [31:0] d);
    @(negedge clk); hitWrEn = hitSel; missWrEn = !hitSel; cntWrData = d;
    @(negedge clk); hitWrEn = 1'b0; missWrEn = 1'b0;
    #1;
    if (hitSel) check(hitCount == d, "R8", "hit counter load", hitCount, d);
    else        check(missCount == d, "R8", "miss counter load", missCount, d);
  endtask

  task automatic doFetch(input logic [19:0] a, input int expLat,
                         input logic [31:0] expData, input string req);
    int cyc = 0;
    bit seen = 0;
    @(negedge clk); fetchReq = 1'b1; fetchAddr = a;
    #1;
    while (!fetchReady && cyc < 100) begin
      if (flashRdEn) begin
        if (!seen) firstFa = flashAddr;
        seen = 1;
        lastFa = flashAddr;
      end
      @(negedge clk); #1; cyc++;
    end
    check(cyc == expLat, req, "fetch latency", cyc, expLat);
    check(fetchData == expData, req, "fetch data", fetchData, expData);
    @(negedge clk); fetchReq = 1'b0;
    #1 check(!fetchReady, "R9", "ready without request", fetchReady, 0);
  endtask

  task automatic checkCounts(input string req);
    check(hitCount == expHit, req, "hit count", hitCount, expHit);
    check(missCount == expMiss, req, "miss count", missCount, expMiss);
  endtask

  task automatic tReset();
    #1;
    check(cfgRdData == 0, "R4", "config reset", cfgRdData, 0);
    check(hitCount == 0 && missCount == 0, "R8", "counters reset", hitCount | missCount, 0);
    check(!fetchReady && !flashRdEn, "R9", "idle outputs", {fetchReady, flashRdEn}, 0);
  endtask

  task automatic tMissThenHit();
    writeCfg(32'h0000_0101);
    doFetch(20'h00124, MISS_LAT, fdata(18'h49, salt), "R2");
    check(firstFa == 18'h48, "R2", "first fill word", firstFa, 18'h48);
    check(lastFa == 18'h4B, "R2", "last fill word", lastFa, 18'h4B);
    expMiss++; checkCounts("R7");
    // new flash content must not show on a hit
    begin
      logic [31:0] oldSalt = salt;
      salt = 32'hDEAD_0000;
      doFetch(20'h00128, 0, fdata(18'h4A, oldSalt), "R1");
    end
    expHit++; checkCounts("R7");
  endtask

  task automatic tConflict();
    doFetch(20'h00924, MISS_LAT, fdata(18'h249, salt), "R3");
    expMiss++;
    doFetch(20'h00124, MISS_LAT, fdata(18'h49, salt), "R3");
    expMiss++;
    doFetch(20'h00124, 0, fdata(18'h49, salt), "R3");
    expHit++; checkCounts("R7");
  endtask

  task automatic tProfileOff();
    writeCfg(32'h0000_0001);
    doFetch(20'h0012C, 0, fdata(18'h4B, salt), "R1");
    doFetch(20'h00500, MISS_LAT, fdata(18'h140, salt), "R2");
    checkCounts("R7");
  endtask

  task automatic tCounterWrite();
    writeCnt(1'b1, 32'h55);
    writeCnt(1'b1, 32'h0);
    writeCnt(1'b0, 32'h0);
    expHit = 0; expMiss = 0;
  endtask

  task automatic tFlashMode();
    writeCfg(32'h0000_0101);
    salt = 32'h1234_5678;
    @(negedge clk); flashMode = 3'b010;
    doFetch(20'h00124, BYP_LAT, fdata(18'h49, salt), "R6");
    check(firstFa == 18'h49, "R6", "bypass word address", firstFa, 18'h49);
    @(negedge clk); flashMode = 3'b100;
    doFetch(20'h00124, BYP_LAT, fdata(18'h49, salt), "R6");
    checkCounts("R6");
    @(negedge clk); flashMode = 3'b000;
    doFetch(20'h00124, MISS_LAT, fdata(18'h49, salt), "R6");
    expMiss++;
    doFetch(20'h00124, 0, fdata(18'h49, salt), "R1");
    expHit++; checkCounts("R7");
  endtask

  task automatic tDisable();
    writeCfg(32'h0000_0100);
    salt = 32'h0F0F_1111;
    doFetch(20'h00124, BYP_LAT, fdata(18'h49, salt), "R5");
    checkCounts("R5");
    writeCfg(32'h0000_0101);
    doFetch(20'h00124, MISS_LAT, fdata(18'h49, salt), "R5");
    expMiss++; checkCounts("R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    tMissThenHit();
    tConflict();
    tProfileOff();
    tCounterWrite();
    tFlashMode();
    tDisable();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule